// File: doc/BRIEF.md
# Bus Slave Response Monitor

This block is a passive observer attached to the response side of one slave on a pipelined AHB-Lite style bus. Every clock it samples the transfer type driven by the master, the bus-wide ready, the slave's own ready and the slave's error response. It raises a flag for each kind of response-signalling fault it sees. It also keeps a running count of the wait states in the transfer now in its data phase. It drives nothing on the bus. Address, data and burst legality are outside its scope.

Four rules are watched. First, an error response must take exactly two cycles: a first cycle with ready low, then a closing cycle with ready high. Second, an error must never appear as a lone one-cycle response. Third, a slave must not stall a transfer for more OKAY wait states than a configured ceiling. Fourth, the master must withdraw its pipelined next transfer, by showing IDLE, during the closing error cycle; this last rule can be disabled by a parameter.

Each flag is a registered, sticky bit. A flag is cleared only by reset or by a synchronous clear strobe. An integration team can therefore leave the monitor in place during long runs or in silicon and read the flags later.

Top module: `slv_resp_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four flags read 0 and the wait count reads 0.
- R2: When a cycle with slave ready low and error high (the first error cycle) is followed by any cycle other than slave ready high with error high, `flag_err_seq` is 1 from the next cycle on.
- R3: When a cycle with slave ready high and error high is not directly preceded by a first error cycle, `flag_lone_err` is 1 from the next cycle on.
- R4: The wait count rises by one after each counted wait cycle and returns to 0 after any cycle with slave ready high. It saturates at MAX_WAIT+1. `flag_latency` sets after the counted wait that takes the count above MAX_WAIT; by default this is the 17th consecutive wait.
- R5: A wait cycle is counted only when the slave's ready and error are both low and the transfer type last accepted (bus ready high) was NONSEQ (2'b10) or SEQ (2'b11). After an accepted IDLE (2'b00) or BUSY (2'b01), waits leave the count at 0.
- R6: When the closing error cycle (ready high, error high, after a first error cycle) carries a transfer type other than IDLE (2'b00), `flag_no_cancel` is 1 from the next cycle on. BUSY counts as a violation.
- R7: With CANCEL_CHK set to 0, `flag_no_cancel` is never set, and the other flags behave as in R2 to R5.
- R8: Flags remain set until cleared. A cycle with `clr` high makes every flag 0 on the next cycle, even if a violation occurs in that same cycle. The clear does not change the wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all flags |
| xfer_type | input | 2 | Transfer type from the master (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| bus_rdy | input | 1 | Bus-wide ready; an address phase is accepted when high |
| slv_rdy | input | 1 | Ready output of the watched slave |
| slv_err | input | 1 | Error response of the watched slave (0 OKAY, 1 ERROR) |
| flag_err_seq | output | 1 | Sticky: error not closed by a ready-high error cycle |
| flag_lone_err | output | 1 | Sticky: single-cycle error response |
| flag_latency | output | 1 | Sticky: wait states exceeded MAX_WAIT |
| flag_no_cancel | output | 1 | Sticky: master did not show IDLE in the closing error cycle |
| wait_cnt | output | CNT_W (5 by default) | OKAY wait states in the current data phase, saturating |

## Verification
The assertions rely on the slave ready and error inputs being known and stable around each clock edge. They also treat a cycle with ready high as the end of a data phase, whether or not the bus ready agrees. The stimulus keeps every input at 0 or 1. It changes inputs just after a rising edge, and mostly ties the bus ready to the slave ready, with occasional divergence. Random traffic is biased to close most error cycles correctly, so the stimulus covers both legal and broken sequences. It also has wait bursts longer than the ceiling, so the latency rule is exercised beyond its boundary.

// File: rtl/slv_mon_pkg.sv
// Package: shared encodings for the slave response monitor.
// Assumes a two-bit transfer type as used on AHB-Lite style buses.
package slv_mon_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } xfer_e;

    // Rule indices into the sticky flag vector.
    localparam int RULE_SEQ    = 0;
    localparam int RULE_LONE   = 1;
    localparam int RULE_LAT    = 2;
    localparam int RULE_CANCEL = 3;
    localparam int NUM_RULES   = 4;

endpackage

// File: rtl/err_seq_check.sv
// Module: err_seq_check
// Watches the slave's ready/error pair and reports, as one-cycle
// hits, broken two-cycle error sequences, lone error cycles and a
// master that fails to show IDLE in the closing error cycle.
// Assumes inputs are synchronous to clk; hits are combinational.
module err_seq_check
    import slv_mon_pkg::*;
#(
    parameter bit CANCEL_CHK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] xfer_type,
    input  logic       slv_rdy,
    input  logic       slv_err,
    output logic       hit_seq,
    output logic       hit_lone,
    output logic       hit_cancel
);

    logic first_q;    // previous cycle was a first error cycle
    logic closing;    // current cycle shows ready high with error

    assign closing = slv_rdy && slv_err;

    // Remember whether the last cycle opened an error response.
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= !slv_rdy && slv_err;
    end

    // Decode sequence faults from the remembered and current cycle.
    always_comb begin
        hit_seq  = first_q && !closing;
        hit_lone = closing && !first_q;
    end

    generate
        if (CANCEL_CHK) begin : g_cancel
            // Closing error cycle must carry IDLE from the master.
            assign hit_cancel = first_q && closing && (xfer_type != TR_IDLE);
        end else begin : g_no_cancel
            assign hit_cancel = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/wait_tracker.sv
// Module: wait_tracker
// Tracks whether a transfer is in its data phase and counts the
// OKAY wait states it receives, saturating at MAX_WAIT+1.
// Reports a latency hit on each counted wait at or beyond the ceiling.
// Assumes bus_rdy high marks acceptance of the current address phase.
module wait_tracker #(
    parameter int MAX_WAIT = 16,
    parameter int CNT_W    = $clog2(MAX_WAIT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_active,
    input  logic             bus_rdy,
    input  logic             slv_rdy,
    input  logic             slv_err,
    output logic [CNT_W-1:0] wait_cnt,
    output logic             hit_lat
);

    localparam logic [CNT_W-1:0] CEIL = CNT_W'(MAX_WAIT);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(MAX_WAIT + 1);

    logic dphase_q;
    logic count_en;

    // Latch data-phase status when an address phase is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       dphase_q <= 1'b0;
        else if (bus_rdy) dphase_q <= addr_active;
    end

    assign count_en = dphase_q && !slv_rdy && !slv_err;
    assign hit_lat  = count_en && (wait_cnt >= CEIL);

    // Count OKAY waits; any ready-high cycle ends the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wait_cnt <= '0;
        else if (slv_rdy)                wait_cnt <= '0;
        else if (count_en && wait_cnt != SAT) wait_cnt <= wait_cnt + 1'b1;
    end

    // R4: a completed transfer leaves the counter at zero.
    a_r4_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        slv_rdy |=> (wait_cnt == '0));

    // R4: the counter never passes its saturation value.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= SAT);

    // R5: outside a data phase the count does not rise.
    a_r5_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!dphase_q && !slv_rdy) |=> $stable(wait_cnt));

endmodule

// File: rtl/sticky_bank.sv
// Module: sticky_bank
// A row of sticky flags; each bit sets on its hit and holds until
// reset or a synchronous clear, which wins over a same-cycle hit.
module sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] hit,
    output logic [N-1:0] flags
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // Set on hit, hold otherwise, drop on reset or clear.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) flags[i] <= 1'b0;
                else if (hit[i])   flags[i] <= 1'b1;
            end
        end
    endgenerate

    // R8: without a clear, no flag ever drops.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // R8: a clear empties the whole bank on the next cycle.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0));

endmodule

// File: rtl/slv_resp_monitor.sv
// Module: slv_resp_monitor (top)
// Passive monitor of one slave's response signalling on a pipelined
// bus: two-cycle error sequence, lone error cycles, wait-state
// ceiling and the master's IDLE in the closing error cycle.
// Assumes all inputs are synchronous to clk; drives nothing on the bus.
module slv_resp_monitor
    import slv_mon_pkg::*;
#(
    parameter int MAX_WAIT   = 16,
    parameter bit CANCEL_CHK = 1'b1,
    localparam int CNT_W     = $clog2(MAX_WAIT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       xfer_type,
    input  logic             bus_rdy,
    input  logic             slv_rdy,
    input  logic             slv_err,
    output logic             flag_err_seq,
    output logic             flag_lone_err,
    output logic             flag_latency,
    output logic             flag_no_cancel,
    output logic [CNT_W-1:0] wait_cnt
);

    logic [NUM_RULES-1:0] hits;
    logic [NUM_RULES-1:0] flags;
    logic                 addr_active;

    assign addr_active = xfer_type[1];   // NONSEQ or SEQ

    err_seq_check #(.CANCEL_CHK(CANCEL_CHK)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_type  (xfer_type),
        .slv_rdy    (slv_rdy),
        .slv_err    (slv_err),
        .hit_seq    (hits[RULE_SEQ]),
        .hit_lone   (hits[RULE_LONE]),
        .hit_cancel (hits[RULE_CANCEL])
    );

    wait_tracker #(.MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)) u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_active (addr_active),
        .bus_rdy     (bus_rdy),
        .slv_rdy     (slv_rdy),
        .slv_err     (slv_err),
        .wait_cnt    (wait_cnt),
        .hit_lat     (hits[RULE_LAT])
    );

    sticky_bank #(.N(NUM_RULES)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (hits),
        .flags (flags)
    );

    assign flag_err_seq   = flags[RULE_SEQ];
    assign flag_lone_err  = flags[RULE_LONE];
    assign flag_latency   = flags[RULE_LAT];
    assign flag_no_cancel = flags[RULE_CANCEL];

    // R2: an opened error not closed next cycle raises the sequence flag.
    a_r2_err_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_rdy && slv_err) ##1 (!(slv_rdy && slv_err) && !clr)
        |=> flag_err_seq);

    // R3: a ready-high error after a non-opening cycle is a lone error.
    a_r3_lone_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(!slv_rdy && slv_err) ##1 (slv_rdy && slv_err && !clr)
        |=> flag_lone_err);

    // R1: nothing is flagged straight after reset.
    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && wait_cnt == '0));

    generate
        if (CANCEL_CHK) begin : g_chk_cancel
            // R6: closing error cycle without IDLE raises the cancel flag.
            a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
                (!slv_rdy && slv_err) ##1
                (slv_rdy && slv_err && xfer_type != TR_IDLE && !clr)
                |=> flag_no_cancel);
        end else begin : g_chk_off
            // R7: a disabled cancel rule never flags.
            a_r7_cancel_off: assert property (@(posedge clk) disable iff (!rst_n)
                !flag_no_cancel);
        end
    endgenerate

endmodule

// File: tb/slv_resp_monitor_bench.sv
// Bench for slv_resp_monitor: directed corner cases followed by
// seeded random traffic, both checked against a cycle model.
module slv_resp_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXW       = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clr;
    logic [1:0] xfer_type;
    logic       bus_rdy, slv_rdy, slv_err;
    logic       f_seq, f_lone, f_lat, f_can;
    logic [4:0] wcnt;
    logic       n_seq, n_lone, n_lat, n_can;
    logic [4:0] n_wcnt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state: flags {cancel, lat, lone, seq}
    logic [3:0] m_flags;
    logic       m_first, m_dph;
    int         m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    slv_resp_monitor #(.MAX_WAIT(MAXW), .CANCEL_CHK(1'b1)) u_slv_resp_monitor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_type(xfer_type),
        .bus_rdy(bus_rdy), .slv_rdy(slv_rdy), .slv_err(slv_err),
        .flag_err_seq(f_seq), .flag_lone_err(f_lone), .flag_latency(f_lat),
        .flag_no_cancel(f_can), .wait_cnt(wcnt)
    );

    slv_resp_monitor #(.MAX_WAIT(MAXW), .CANCEL_CHK(1'b0)) u_slv_resp_monitor_nc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_type(xfer_type),
        .bus_rdy(bus_rdy), .slv_rdy(slv_rdy), .slv_err(slv_err),
        .flag_err_seq(n_seq), .flag_lone_err(n_lone), .flag_latency(n_lat),
        .flag_no_cancel(n_can), .wait_cnt(n_wcnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare both instances against the model.
    task automatic cmp_model();
        chk("R2 err_seq",   f_seq,  m_flags[0]);
        chk("R3 lone_err",  f_lone, m_flags[1]);
        chk("R4 latency",   f_lat,  m_flags[2]);
        chk("R6 no_cancel", f_can,  m_flags[3]);
        chk("R4 wait_cnt",  wcnt,   m_cnt);
        chk("R7 nc err_seq",   n_seq,  m_flags[0]);
        chk("R7 nc lone_err",  n_lone, m_flags[1]);
        chk("R7 nc latency",   n_lat,  m_flags[2]);
        chk("R7 nc no_cancel", n_can,  0);
        chk("R7 nc wait_cnt",  n_wcnt, m_cnt);
    endtask

    // Apply one cycle of inputs, advance the model, then compare.
    task automatic drive(input logic [1:0] tr, input logic ri, input logic ro,
                         input logic er, input logic cl);
        logic [3:0] hits;
        logic       en;
        xfer_type = tr; bus_rdy = ri; slv_rdy = ro; slv_err = er; clr = cl;
        en      = m_dph && !ro && !er;
        hits[0] = m_first && !(ro && er);
        hits[1] = ro && er && !m_first;
        hits[2] = en && (m_cnt >= MAXW);
        hits[3] = m_first && ro && er && (tr != 2'b00);
        @(posedge clk);
        #1;
        m_flags = cl ? 4'b0 : (m_flags | hits);
        if (ro)                          m_cnt = 0;
        else if (en && m_cnt < MAXW + 1) m_cnt = m_cnt + 1;
        m_first = !ro && er;
        if (ri) m_dph = tr[1];
        cmp_model();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int burst;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; clr = 1'b0; xfer_type = 2'b00;
        bus_rdy = 1'b1; slv_rdy = 1'b1; slv_err = 1'b0;
        m_flags = '0; m_first = 1'b0; m_dph = 1'b0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 flags", {f_can, f_lat, f_lone, f_seq}, 0);
        chk("R1 wait_cnt", wcnt, 0);
        rst_n = 1'b1;
        drive(2'b00, 1, 1, 0, 0);
        chk("R1 flags after release", {f_can, f_lat, f_lone, f_seq}, 0);

        // R4: 16 waits stay legal, 17th flags, count saturates at 17
        drive(2'b10, 1, 1, 0, 0);
        for (int i = 0; i < 16; i++) drive(2'b00, 0, 0, 0, 0);
        chk("R4 cnt at ceiling", wcnt, 16);
        chk("R4 no latency at ceiling", f_lat, 0);
        drive(2'b00, 0, 0, 0, 0);
        chk("R4 cnt above ceiling", wcnt, 17);
        chk("R4 latency set", f_lat, 1);
        drive(2'b00, 0, 0, 0, 0);
        chk("R4 cnt saturated", wcnt, 17);
        drive(2'b00, 1, 1, 0, 0);
        chk("R4 cnt cleared on ready", wcnt, 0);
        drive(2'b00, 1, 1, 0, 0);
        chk("R8 latency sticky", f_lat, 1);
        drive(2'b00, 1, 1, 0, 1);
        chk("R8 cleared", {f_can, f_lat, f_lone, f_seq}, 0);

        // R5: waits after accepted IDLE and BUSY are not counted
        drive(2'b00, 0, 0, 0, 0);
        drive(2'b00, 0, 0, 0, 0);
        chk("R5 idle no count", wcnt, 0);
        drive(2'b01, 1, 1, 0, 0);
        drive(2'b00, 0, 0, 0, 0);
        chk("R5 busy no count", wcnt, 0);
        drive(2'b00, 1, 1, 0, 0);

        // R2/R3/R6: legal two-cycle error with IDLE
        drive(2'b10, 1, 1, 0, 0);
        drive(2'b10, 0, 0, 0, 0);
        chk("R5 counted wait", wcnt, 1);
        drive(2'b10, 0, 0, 1, 0);
        chk("R5 error cycle not counted", wcnt, 1);
        drive(2'b00, 1, 1, 1, 0);
        chk("R2 R3 R6 legal error clean", {f_can, f_lat, f_lone, f_seq}, 0);

        // R6/R7: BUSY in closing cycle
        drive(2'b10, 1, 1, 0, 0);
        drive(2'b10, 0, 0, 1, 0);
        drive(2'b01, 1, 1, 1, 0);
        chk("R6 cancel flagged", f_can, 1);
        chk("R6 only cancel", {f_lat, f_lone, f_seq}, 0);
        chk("R7 disabled cancel", n_can, 0);
        drive(2'b00, 1, 1, 0, 1);

        // R2: opened error followed by OKAY ready
        drive(2'b10, 1, 1, 0, 0);
        drive(2'b10, 0, 0, 1, 0);
        drive(2'b00, 1, 1, 0, 0);
        chk("R2 broken sequence", f_seq, 1);
        drive(2'b00, 1, 1, 0, 1);

        // R3: lone error, stickiness, clear beating same-cycle hit
        drive(2'b00, 1, 1, 1, 0);
        chk("R3 lone error", f_lone, 1);
        drive(2'b00, 1, 1, 0, 0);
        drive(2'b00, 1, 1, 0, 0);
        chk("R8 lone sticky", f_lone, 1);
        drive(2'b00, 1, 1, 1, 1);
        chk("R8 clear wins", {f_can, f_lat, f_lone, f_seq}, 0);

        // R8: clear leaves the wait count alone
        drive(2'b10, 1, 1, 0, 0);
        for (int i = 0; i < 3; i++) drive(2'b00, 0, 0, 0, 0);
        drive(2'b00, 0, 0, 0, 1);
        chk("R8 clear keeps count", wcnt, 4);
        drive(2'b00, 1, 1, 0, 0);

        // Random traffic
        burst = 0;
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] tr;
            logic ri, ro, er, cl;
            tr = 2'($urandom % 4);
            ro = ($urandom % 100) < 55;
            er = ($urandom % 100) < 8;
            cl = ($urandom % 100) < 3;
            if (burst == 0 && ($urandom % 100) < 2) burst = 14 + ($urandom % 8);
            if (burst > 0) begin
                ro = 1'b0; er = 1'b0; burst--;
            end
            if (m_first && ($urandom % 4) != 0) begin
                ro = 1'b1; er = 1'b1;
                if (($urandom % 3) != 0) tr = 2'b00;
            end
            ri = (($urandom % 10) == 0) ? 1'($urandom % 2) : ro;
            drive(tr, ri, ro, er, cl);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule